// File: doc/BRIEF.md
# Retriggerable Three-Cycle One-Shot

This block turns a slow, unsynchronised level input into a clean pulse aligned to the clock. On each rising clock edge it samples the trigger input. A trigger is a sample of 1 whose previous sample was 0. A trigger drives the output high for a fixed number of clock periods, three by default. The pulse starts on the edge that samples the trigger; it does not start at the moment the input rises.

A new trigger that arrives while the pulse is running restarts the full window, so the pulse grows. A level that simply stays high is not a new trigger. Once its window has run out the output drops, and it stays low until the input has been sampled low and then high again. The output is a function of stored state only (Moore form), so it changes only just after a clock edge.

Top module: `oneshot_retrig`

## Requirements
- R1: While `rst_ni` is low the output `z_o` is 0, and this takes effect without waiting for a clock edge. Reset also forgets the previous input sample, so a 1 on the first edge after release counts as a trigger.
- R2: A trigger is a rising clock edge that samples `x_i` = 1 when the sample at the previous edge was 0. `z_o` is 1 right after the edge that samples a trigger.
- R3: After one trigger with no later trigger, `z_o` stays 1 for exactly `PULSE_LEN` clock periods (3 by default), counted from the trigger edge. It then returns to 0.
- R4: A trigger sampled while `z_o` is 1 restarts the window. `z_o` then stays 1 for `PULSE_LEN` periods counted from that later edge.
- R5: When `x_i` is held at 1 across many edges, only its first sample is a trigger. `z_o` falls `PULSE_LEN` periods after that edge and stays 0 until `x_i` is sampled 0 and then 1.
- R6: After a trigger, samples of `x_i` = 0 do not shorten the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Trigger level, sampled each rising edge |
| z_o | output | 1 | Pulse output, aligned to the clock |

## Verification
The assertions take it for granted that `x_i` holds a clean 0 or 1 at each rising edge. In a real system a synchroniser placed in front of this block would guarantee that. They also assume `x_i` is held low while reset is asserted, so the checker's own record of the previous sample starts in step with the design. The stimulus changes `x_i` only on falling edges and keeps it at 0 around every reset. Under those conditions every pattern the sweep applies is a legal sampled sequence.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Remaining-period count after one clock edge.
  // A trigger reloads the full window; otherwise the count falls to zero.
  // Any code above the window length is treated as corrupt and returns to idle.
  function automatic int next_remaining(input bit trig, input int rem, input int len);
    if (trig) return len;
    if (rem <= 0 || rem > len) return 0;
    return rem - 1;
  endfunction

  // A sample counts as a trigger only when the previous sample was low.
  function automatic bit is_trigger(input bit now_s, input bit before_s);
    return now_s && !before_s;
  endfunction

  // Width needed to hold the values 0..len.
  function automatic int count_width(input int len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction

endpackage

// File: rtl/oneshot_edge_sense.sv
module oneshot_edge_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic trig_o
);
  import oneshot_pkg::*;

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= x_i;
  end

  assign trig_o = is_trigger(x_i, prev_q);

endmodule

// File: rtl/oneshot_window.sv
module oneshot_window #(
  parameter int PULSE_LEN = 3,
  localparam int CNT_W = oneshot_pkg::count_width(PULSE_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o,
  output logic expire_o
);
  import oneshot_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(next_remaining(trig_i, int'(cnt_q), PULSE_LEN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
  assign expire_o = (cnt_q == CNT_W'(1)) && !trig_i;

endmodule

// File: rtl/oneshot_retrig.sv
module oneshot_retrig #(
  parameter int PULSE_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_o
);

  logic trig_w;
  logic active_w;
  logic expire_w;

  oneshot_edge_sense u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .trig_o (trig_w)
  );

  oneshot_window #(.PULSE_LEN(PULSE_LEN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig_w),
    .active_o (active_w),
    .expire_o (expire_w)
  );

  assign z_o = active_w;

endmodule

// File: rtl/oneshot_retrig_chk.sv
module oneshot_retrig_chk #(
  parameter int PULSE_LEN = 3,
  localparam int AGE_W = $clog2(PULSE_LEN + 2) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic x_i,
  input logic z_o,
  input logic trig_w,
  input logic expire_w
);

  logic             xs_q;
  logic [AGE_W-1:0] age_q;
  logic             seen_trig;

  assign seen_trig = x_i && !xs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xs_q  <= 1'b0;
      age_q <= '0;
    end else begin
      xs_q <= x_i;
      if (seen_trig)                                 age_q <= AGE_W'(1);
      else if (age_q != '0 && age_q <= AGE_W'(PULSE_LEN)) age_q <= age_q + AGE_W'(1);
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !z_o);

  // R2
  trig_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_trig |=> z_o);

  // R2
  trig_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_w == seen_trig);

  // R4
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o == (age_q >= AGE_W'(1) && age_q <= AGE_W'(PULSE_LEN)));

  // R3
  expire_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_w |=> !z_o);

  // R5
  held_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i && xs_q && !z_o) |=> !z_o);

  // R6
  no_early_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_o && !x_i && age_q < AGE_W'(PULSE_LEN)) |=> z_o);

endmodule

bind oneshot_retrig oneshot_retrig_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .x_i      (x_i),
  .z_o      (z_o),
  .trig_w   (trig_w),
  .expire_w (expire_w)
);

// File: tb/oneshot_retrig_tb.sv
`timescale 1ns/1ps
module oneshot_retrig_tb;
  localparam int LEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic z;

  int checks = 0;
  int errors = 0;

  // bench model: history in cycle indices
  int  cyc = 0;
  int  last_trig = 0;
  bit  have_trig = 1'b0;
  bit  m_prev = 1'b0;

  always #5 clk = ~clk;

  oneshot_retrig #(.PULSE_LEN(LEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .z_o(z)
  );

  task automatic check(input string req, input bit exp);
    checks++;
    if (z !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: z=%b expected %b", req, cyc, z, exp);
    end
  endtask

  // drive x for one edge, then compare just after the edge
  task automatic step(input bit v, input string req);
    @(negedge clk);
    x = v;
    @(posedge clk);
    #1;
    cyc++;
    if (v && !m_prev) begin
      have_trig = 1'b1;
      last_trig = cyc;
    end
    m_prev = v;
    check(req, have_trig && (cyc - last_trig) < LEN);
  endtask

  task automatic do_reset();
    @(negedge clk);
    x = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", 1'b0);
    @(posedge clk);
    #1;
    check("R1", 1'b0);
    have_trig = 1'b0;
    m_prev = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    check("R1", 1'b0);
    do_reset();

    // R2 R3: single trigger then low
    step(1'b1, "R2");
    for (int i = 0; i < 6; i++) step(1'b0, "R3");

    // R4: retrigger at the third pulse cycle
    step(1'b1, "R2");
    step(1'b0, "R6");
    step(1'b1, "R4");
    for (int i = 0; i < 5; i++) step(1'b0, "R4");

    // R4: retrigger at the edge where the pulse would end
    step(1'b1, "R2");
    step(1'b0, "R6");
    step(1'b0, "R6");
    step(1'b1, "R4");
    for (int i = 0; i < 5; i++) step(1'b0, "R4");

    // R5: level held high for many cycles
    for (int i = 0; i < 20; i++) step(1'b1, "R5");
    step(1'b0, "R5");
    step(1'b1, "R5");
    for (int i = 0; i < 5; i++) step(1'b0, "R5");

    // R1: reset in mid-pulse, then a 1 right after release triggers
    step(1'b1, "R2");
    do_reset();
    step(1'b1, "R1");
    for (int i = 0; i < 4; i++) step(1'b0, "R3");

    // exhaustive sweep over all 10-sample patterns
    for (int p = 0; p < 1024; p++) begin
      for (int b = 0; b < 10; b++) step(p[b], "R4");
      for (int b = 0; b < LEN + 1; b++) step(1'b0, "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule